// File: doc/BRIEF.md
# Sequenced-Service Watchdog Timer

This block watches that software keeps running. It counts steps of a slow reference strobe and raises a reset request when the count reaches a selectable limit before software has serviced it. Software reaches the block through a plain write port that decodes two addresses. One holds a configuration word. The other is a service register.

The configuration word takes effect only on its first write after reset. It selects the timeout length, the step source (the reference strobe or every clock) and a windowed mode. A service counts only when two fixed byte values land in the service register in the right order: first 0x55, then 0xAA. Any number of writes to other addresses may come between the two halves. In windowed mode, a service that completes too early is itself treated as a fault.

The reset request is a single-cycle pulse. A sticky flag records that a request was raised, and only a system reset clears it. The clock generator and the system reset controller sit outside the block.

Top module: `svc_watchdog`

## Requirements
- R1: After reset, `rst_req_o` and `timeout_flag_o` are 0. The active configuration is timeout code 11, strobe step source, window mode off.
- R2: Configuration bit 1 picks the step source. At 0, only clock cycles with `tick_i` high advance the count. At 1, every clock cycle advances it.
- R3: Configuration bits 3:2 pick the limit: 01 gives 2^SHIFT_SHORT steps, 10 gives 2^SHIFT_MID steps, and 11 gives 2^SHIFT_LONG steps. The clock edge that registers the limit-th step since the last clear drives `rst_req_o` high for exactly one cycle. That same edge restarts the count from zero.
- R4: Timeout code 00 disables the block. The count is held at zero, and no request is raised for any stimulus, services included.
- R5: The first write to CFG_ADDR after reset loads `wr_data_i[3:0]` as the configuration. Every later write to CFG_ADDR is ignored until the next reset.
- R6: A write to CFG_ADDR, accepted or ignored, does not clear the count. A step in that same cycle is still counted.
- R7: Writing 0x55 and then 0xAA to SVC_ADDR completes a service. The count becomes zero on the edge of the 0xAA write, and this takes priority over a step in that cycle.
- R8: Writes to other addresses between the two halves do not break the sequence. Idle cycles between them do not break it either, and neither does a repeated 0x55.
- R9: A 0xAA written without a pending 0x55 has no effect. Any other value written to SVC_ADDR cancels a pending 0x55.
- R10: Configuration bit 0 enables window mode. In this mode, a service whose 0xAA write sees a count below three quarters of the limit raises `rst_req_o` on that same edge. The count is still cleared. A service at or above that point is accepted silently.
- R11: Every request sets `timeout_flag_o`. The flag stays 1 until a reset, and services do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Reference step strobe, one cycle per reference period |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Write address (CFG_ADDR or SVC_ADDR) |
| wr_data_i | input | DATA_W | Write data |
| rst_req_o | output | 1 | One-cycle reset request pulse |
| timeout_flag_o | output | 1 | Sticky record of any request |

## Verification
The bench builds the block with SHIFT_SHORT=2, SHIFT_MID=3 and SHIFT_LONG=4, which gives limits of 4, 8 and 16 steps. These small limits let it cover every timeout code, both step sources and two strobe spacings, with the exact expiry cycle computed for each combination. They also put the window boundary at count 12, so service sequences can be placed one cycle on either side of it. The same short limits keep the ordering cases (interleaved writes, broken and repeated halves) and the write-once lock within a few dozen cycles each.

// File: rtl/svc_wdog_pkg.sv
package svc_wdog_pkg;

    typedef enum logic [1:0] {
        TSEL_OFF   = 2'b00,
        TSEL_SHORT = 2'b01,
        TSEL_MID   = 2'b10,
        TSEL_LONG  = 2'b11
    } tsel_e;

    // Packed so that tsel sits at bits 3:2, src at bit 1 and win at bit 0.
    typedef struct packed {
        tsel_e tsel;
        logic  src;
        logic  win;
    } cfg_t;

    localparam cfg_t CFG_RESET  = '{tsel: TSEL_LONG, src: 1'b0, win: 1'b0};
    localparam logic [7:0] SVC_FIRST  = 8'h55;
    localparam logic [7:0] SVC_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        SVC_OTHER,
        SVC_ARM,
        SVC_FIRE
    } svc_kind_e;

    function automatic int unsigned tsel_shift(input tsel_e ts,
                                               input int unsigned s_short,
                                               input int unsigned s_mid,
                                               input int unsigned s_long);
        case (ts)
            TSEL_SHORT: return s_short;
            TSEL_MID:   return s_mid;
            default:    return s_long;
        endcase
    endfunction

endpackage

// File: rtl/wdog_cfg_lock.sv
module wdog_cfg_lock
    import svc_wdog_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_wr_i,
    input  cfg_t cfg_data_i,
    output cfg_t cfg_o
);
    cfg_t cfg_q;
    logic locked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= CFG_RESET;
            locked_q <= 1'b0;
        end else if (cfg_wr_i && !locked_q) begin
            cfg_q    <= cfg_data_i;
            locked_q <= 1'b1;
        end
    end

    assign cfg_o = cfg_q;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> $stable(cfg_q)); // R5

endmodule

// File: rtl/wdog_svc_seq.sv
module wdog_svc_seq
    import svc_wdog_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              svc_wr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              svc_done_o
);
    svc_kind_e kind;
    logic      armed_q;

    always_comb begin
        if (data_i == DATA_W'(SVC_FIRST))
            kind = SVC_ARM;
        else if (data_i == DATA_W'(SVC_SECOND))
            kind = SVC_FIRE;
        else
            kind = SVC_OTHER;
    end

    assign svc_done_o = svc_wr_i && (kind == SVC_FIRE) && armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (svc_wr_i) begin
            case (kind)
                SVC_ARM:  armed_q <= 1'b1;
                SVC_FIRE: armed_q <= 1'b0;
                default:  armed_q <= 1'b0;
            endcase
        end
    end

    AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (rst)
        svc_done_o |=> !armed_q); // R7

endmodule

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter
    import svc_wdog_pkg::*;
#(
    parameter int unsigned SHIFT_SHORT = 5,
    parameter int unsigned SHIFT_MID   = 8,
    parameter int unsigned SHIFT_LONG  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  cfg_t cfg_i,
    input  logic svc_done_i,
    output logic rst_req_o,
    output logic timeout_flag_o
);
    localparam int CNT_W = SHIFT_LONG + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] win_lo;
    logic             step;
    logic             enabled;
    logic             req_q;
    logic             flag_q;

    always_comb begin
        limit   = CNT_W'(1) << tsel_shift(cfg_i.tsel, SHIFT_SHORT, SHIFT_MID, SHIFT_LONG);
        win_lo  = limit - (limit >> 2);
        step    = cfg_i.src ? 1'b1 : tick_i;
        enabled = (cfg_i.tsel != TSEL_OFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            req_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (!enabled) begin
                cnt_q <= '0;
            end else if (svc_done_i) begin
                cnt_q <= '0;
                if (cfg_i.win && (cnt_q < win_lo)) begin
                    req_q  <= 1'b1;
                    flag_q <= 1'b1;
                end
            end else if (step) begin
                if (cnt_q >= limit - CNT_W'(1)) begin
                    cnt_q  <= '0;
                    req_q  <= 1'b1;
                    flag_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    assign rst_req_o      = req_q;
    assign timeout_flag_o = flag_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        flag_q |=> flag_q); // R11
    AST_REQ_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        req_q |-> flag_q); // R11
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.tsel == TSEL_OFF) |=> !req_q); // R4
    AST_SVC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (svc_done_i && enabled) |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
    import svc_wdog_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CFG_ADDR    = 0,
    parameter int unsigned SVC_ADDR    = 1,
    parameter int unsigned SHIFT_SHORT = 5,
    parameter int unsigned SHIFT_MID   = 8,
    parameter int unsigned SHIFT_LONG  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              rst_req_o,
    output logic              timeout_flag_o
);
    logic cfg_wr;
    logic svc_wr;
    logic svc_done;
    cfg_t cfg;

    assign cfg_wr = wr_en_i && (wr_addr_i == ADDR_W'(CFG_ADDR));
    assign svc_wr = wr_en_i && (wr_addr_i == ADDR_W'(SVC_ADDR));

    wdog_cfg_lock u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr_i   (cfg_wr),
        .cfg_data_i (cfg_t'(wr_data_i[3:0])),
        .cfg_o      (cfg)
    );

    wdog_svc_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .svc_wr_i   (svc_wr),
        .data_i     (wr_data_i),
        .svc_done_o (svc_done)
    );

    wdog_tick_counter #(
        .SHIFT_SHORT (SHIFT_SHORT),
        .SHIFT_MID   (SHIFT_MID),
        .SHIFT_LONG  (SHIFT_LONG)
    ) u_cnt (
        .clk            (clk),
        .rst            (rst),
        .tick_i         (tick_i),
        .cfg_i          (cfg),
        .svc_done_i     (svc_done),
        .rst_req_o      (rst_req_o),
        .timeout_flag_o (timeout_flag_o)
    );

endmodule

// File: tb/svc_watchdog_bench.sv
module svc_watchdog_bench;
    localparam int CLK_PERIOD = 10;
    localparam int S_SHORT = 2, S_MID = 3, S_LONG = 4;
    localparam logic [3:0] A_CFG = 4'd0, A_SVC = 4'd1, A_OTHER = 4'd2;

    logic clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] data = '0;
    logic req, flag;
    int n_chk = 0, n_bad = 0, cyc = 0, first_pulse = 0, pulse_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    svc_watchdog #(.ADDR_W(4), .DATA_W(8), .CFG_ADDR(0), .SVC_ADDR(1),
                   .SHIFT_SHORT(S_SHORT), .SHIFT_MID(S_MID), .SHIFT_LONG(S_LONG))
    u_svc_watchdog (.clk(clk), .rst(rst), .tick_i(tick), .wr_en_i(wr_en),
                    .wr_addr_i(addr), .wr_data_i(data),
                    .rst_req_o(req), .timeout_flag_o(flag));

    function automatic int lim(input int ts);
        return 1 << ((ts == 1) ? S_SHORT : (ts == 2) ? S_MID : S_LONG);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clk1(input logic t, input logic we, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        tick = t; wr_en = we; addr = a; data = d;
        @(posedge clk); #1;
        cyc++;
        if (req) begin
            pulse_cnt++;
            if (first_pulse == 0) first_pulse = cyc;
        end
    endtask

    task automatic run_ticks(input int upto, input int per);
        while (cyc < upto) clk1(((cyc + 1) % per) == 0, 1'b0, A_CFG, 8'h00);
    endtask

    task automatic clear_counts();
        cyc = 0; first_pulse = 0; pulse_cnt = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tick = 1'b0; wr_en = 1'b0; addr = '0; data = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        clear_counts();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state and default 2^S_LONG strobe-based limit
        do_reset();
        check("R1 req after reset", int'(req), 0);
        check("R1 flag after reset", int'(flag), 0);
        run_ticks(lim(3) + 1, 1);
        check("R1 default limit", first_pulse, lim(3));
        check("R11 flag set", int'(flag), 1);
        run_ticks(2 * lim(3) + 1, 1);
        check("R3 restart count", pulse_cnt, 2);

        // R2 R3 R4 sweep: every code, both sources, two strobe spacings
        for (int ts = 0; ts < 4; ts++)
            for (int src = 0; src < 2; src++)
                for (int per = 1; per <= 3; per += 2) begin
                    do_reset();
                    clk1(1'b0, 1'b1, A_CFG, 8'(ts * 4 + src * 2));
                    clear_counts();
                    if (ts == 0) begin
                        run_ticks(40, per);
                        check("R4 disabled no pulse", first_pulse, 0);
                        check("R4 disabled flag", int'(flag), 0);
                    end else begin
                        int exp;
                        exp = (src == 1) ? lim(ts) : lim(ts) * per;
                        run_ticks(exp + 1, per);
                        check("R2/R3 expiry cycle", first_pulse, exp);
                        check("R3 single pulse", pulse_cnt, 1);
                        check("R11 flag on expiry", int'(flag), 1);
                    end
                end

        // R4 disabled with window mode: an early service still raises nothing
        do_reset();
        clk1(1'b0, 1'b1, A_CFG, 8'h01);
        clear_counts();
        run_ticks(3, 1);
        clk1(1'b1, 1'b1, A_SVC, 8'h55);
        clk1(1'b1, 1'b1, A_SVC, 8'hAA);
        run_ticks(30, 1);
        check("R4 disabled window service", first_pulse, 0);

        // R5 R6 write once, cfg write keeps count; second write (disable) ignored
        do_reset();
        run_ticks(4, 1);
        clk1(1'b1, 1'b1, A_CFG, 8'h0C);
        run_ticks(7, 1);
        clk1(1'b1, 1'b1, A_CFG, 8'h00);
        run_ticks(lim(3) + 1, 1);
        check("R5/R6 locked config, count kept", first_pulse, lim(3));

        // R5 first write selects short limit, later long write ignored
        do_reset();
        clk1(1'b0, 1'b1, A_CFG, 8'h04);
        clk1(1'b0, 1'b1, A_CFG, 8'h0C);
        clear_counts();
        run_ticks(lim(1) + 1, 1);
        check("R5 first write wins", first_pulse, lim(1));

        // R7 R8 service split by other-address writes
        do_reset();
        run_ticks(9, 1);
        clk1(1'b1, 1'b1, A_SVC, 8'h55);
        clk1(1'b1, 1'b0, A_CFG, 8'h00);
        clk1(1'b1, 1'b1, A_OTHER, 8'h12);
        clk1(1'b1, 1'b1, A_SVC, 8'hAA);
        run_ticks(40, 1);
        check("R7/R8 interleaved service", first_pulse, 13 + lim(3));

        // R8 repeated first half still arms
        do_reset();
        run_ticks(4, 1);
        clk1(1'b1, 1'b1, A_SVC, 8'h55);
        clk1(1'b1, 1'b1, A_SVC, 8'h55);
        clk1(1'b1, 1'b1, A_SVC, 8'hAA);
        run_ticks(30, 1);
        check("R8 repeated 0x55", first_pulse, 7 + lim(3));

        // R9 lone 0xAA ignored
        do_reset();
        run_ticks(9, 1);
        clk1(1'b1, 1'b1, A_SVC, 8'hAA);
        run_ticks(20, 1);
        check("R9 lone 0xAA", first_pulse, lim(3));

        // R9 other value cancels pending half
        do_reset();
        run_ticks(4, 1);
        clk1(1'b1, 1'b1, A_SVC, 8'h55);
        clk1(1'b1, 1'b1, A_SVC, 8'h12);
        clk1(1'b1, 1'b1, A_SVC, 8'hAA);
        run_ticks(20, 1);
        check("R9 broken sequence", first_pulse, lim(3));

        // R10 window mode: boundary at count 12 for limit 16
        do_reset();
        clk1(1'b0, 1'b1, A_CFG, 8'h0D);
        clear_counts();
        run_ticks(6, 1);
        clk1(1'b1, 1'b1, A_SVC, 8'h55);
        clk1(1'b1, 1'b1, A_SVC, 8'hAA);
        check("R10 early service pulse", first_pulse, 8);
        check("R10 early service flag", int'(flag), 1);
        run_ticks(8 + lim(3), 1);
        check("R10 count cleared by early service", first_pulse == 8 && pulse_cnt == 2 ? 1 : 0, 1);

        do_reset();
        clk1(1'b0, 1'b1, A_CFG, 8'h0D);
        clear_counts();
        run_ticks(10, 1);
        clk1(1'b1, 1'b1, A_SVC, 8'h55);
        clk1(1'b1, 1'b1, A_SVC, 8'hAA);
        check("R10 one below window", first_pulse, 12);

        do_reset();
        clk1(1'b0, 1'b1, A_CFG, 8'h0D);
        clear_counts();
        run_ticks(11, 1);
        clk1(1'b1, 1'b1, A_SVC, 8'h55);
        clk1(1'b1, 1'b1, A_SVC, 8'hAA);
        run_ticks(40, 1);
        check("R10 in-window service", first_pulse, 13 + lim(3));
        check("R11 flag after in-window", int'(flag), 1);

        // R11 flag survives a service, cleared only by reset
        clk1(1'b1, 1'b1, A_SVC, 8'h55);
        clk1(1'b1, 1'b1, A_SVC, 8'hAA);
        check("R11 flag after service", int'(flag), 1);
        do_reset();
        check("R11 flag cleared by reset", int'(flag), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule